// File: doc/BRIEF.md
# OTG Boost Enable Sequencer

This block decides when the charger's power bridge may be reused as a 5 V boost converter for a USB on-the-go bus, and it walks the converter through its start-up. A boost session begins only when the host has set the boost enable bit and the hardware permits it. The permit requires four things: the input supply is absent (below its undervoltage lockout), the active-low charger enable pin is held high, the battery is above its 3 V lockout, and neither the shutdown pin nor thermal shutdown is active.

Once a session is permitted, the sequencer steps through a fixed start-up. It waits, then runs a linear soft-start through the reverse-blocking PMOS, then a switching soft-start, then a frequency ramp. Each phase lasts a parameterised number of 1 ms ticks. After the ramp the converter runs. Protective exits have an order of precedence. A short on the output during start-up comes first. Output over-voltage that persists beyond a deglitch window comes next. Reaching the selected average battery-current limit comes last. Loss of any permit condition also ends the session. Every stop passes through a PMOS turn-off phase into a shutdown state. A new session requires the enable bit to be cleared and then set again.

The analog regulation loop and current sensing are outside the block. The block sees a digital average battery current in mA, a current-limit selection and comparator flags, and it drives a 3-bit status code and one enable per gate-control phase.

Top module: `otg_boost_seq`

## Requirements
- R1: The sequencer leaves idle (status 0) for wait (status 1) only while `otg_en_reg`=1, `chg_en_n`=1, `vin_uvlo`=1, `bat_uvlo`=0, `shdn`=0 and `tsd`=0; with any of these unmet it stays in idle.
- R2: `boost_state` encodes 0 idle, 1 wait, 2 linear soft-start, 3 switching soft-start, 4 frequency ramp, 5 run, 6 PMOS-off, 7 shutdown. The start-up visits 1,2,3,4 in order, each for exactly WAIT_TICKS, LIN_TICKS, SW_TICKS and RAMP_TICKS ticks, and then enters 5.
- R3: The gate enables follow the state. `lin_ss_en` is active only in 2. `sw_ss_en` is active in 3, 4 and 5. `framp_en` is active only in 4. `run_en` is active only in 5. `pmos_en` is active in 2 to 5.
- R4: In states 1 to 5, losing any permit condition of R1 moves the sequencer to 6 on the next clock, with no alarm.
- R5: `vout_ovp` sampled high on more than OVP_TICKS consecutive ticks while boosting (30 by default) stops boost (state 6) and pulses `alm_ovp`. A drop of the flag restarts the count.
- R6: `ilim_sel` selects the average-current limit: 00=350 mA, 01=450 mA, 10=550 mA, 11=950 mA. When `ibat_avg` is at or above the limit while boosting, boost stops (state 6) and `alm_ilim` pulses.
- R7: `vout_short` in states 1 to 4 stops boost, sets `short_sticky` and pulses `alm_short`. In state 5 it is ignored. `short_sticky` clears when the next session starts.
- R8: State 6 lasts PMOFF_TICKS ticks and then enters 7. State 7 returns to 0 only once `otg_en_reg` is 0.
- R9: After reset, the state is 0, all gate enables are low, `short_sticky` is 0 and no alarm is active.
- R10: Each alarm is a single-cycle pulse and at most one alarm fires per stop. When several faults occur together, the priority is short, then over-voltage, then current limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every 1 ms |
| otg_en_reg | input | 1 | Boost enable bit from the register file |
| chg_en_n | input | 1 | Active-low charger enable pin (high permits boost) |
| shdn | input | 1 | Shutdown pin, high holds the converter off |
| vin_uvlo | input | 1 | High when the input supply is below its UVLO |
| bat_uvlo | input | 1 | High when the battery is below 3 V |
| tsd | input | 1 | Thermal shutdown flag |
| vout_ovp | input | 1 | Output over-voltage comparator |
| vout_short | input | 1 | Output short comparator |
| ibat_avg | input | IW | Average battery current, mA |
| ilim_sel | input | 2 | Average-current limit select |
| boost_state | output | 3 | Encoded sequencer state |
| lin_ss_en | output | 1 | Linear soft-start gate control |
| sw_ss_en | output | 1 | Switching enable |
| framp_en | output | 1 | Frequency ramp control |
| run_en | output | 1 | Full-frequency run control |
| pmos_en | output | 1 | Reverse-blocking PMOS on |
| short_sticky | output | 1 | Start-up short seen in this session |
| alm_short | output | 1 | Short-circuit alarm pulse |
| alm_ovp | output | 1 | Output over-voltage alarm pulse |
| alm_ilim | output | 1 | Average-current limit alarm pulse |

## Verification
The hardest case to reach is an over-voltage flag that has almost, but not quite, lasted the deglitch window. The bench must hold the converter in run and feed the flag for exactly OVP_TICKS ticks without a trip. It must then show that one more tick trips. Separately, it must show that dropping the flag for a single cycle between two long high stretches restarts the count. The stimulus table first walks the sequencer into run with an exact tick budget, then applies those tick counts. Alarm pulses are counted on every cycle and compared against the number of faulted stops.

// File: rtl/otgseq_pkg.sv
// Package: shared state encoding for the boost sequencer.
// Assumes: the encoding is decoded by status consumers, so values are fixed.
package otgseq_pkg;

    typedef enum logic [2:0] {
        BST_IDLE  = 3'd0,
        BST_WAIT  = 3'd1,
        BST_LINSS = 3'd2,
        BST_SWSS  = 3'd3,
        BST_FRAMP = 3'd4,
        BST_RUN   = 3'd5,
        BST_PMOFF = 3'd6,
        BST_SHUT  = 3'd7
    } bst_state_e;

    // Average battery current limit in mA for a 2-bit select code.
    function automatic logic [10:0] ilim_ma(input logic [1:0] sel);
        case (sel)
            2'b00:   ilim_ma = 11'd350;
            2'b01:   ilim_ma = 11'd450;
            2'b10:   ilim_ma = 11'd550;
            default: ilim_ma = 11'd950;
        endcase
    endfunction

endpackage

// File: rtl/otgseq_deglitch.sv
// Module: tick-based persistence filter.
// Counts consecutive ticks on which a flag is high and pulses trip on the
// tick that exceeds LIMIT. Any low sample or clr restarts the count.
// Assumes: tick is a single-cycle pulse; flag is already synchronous.
module otgseq_deglitch #(
    parameter int LIMIT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flag,
    input  logic tick,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 2);

    logic [CW-1:0] cnt;

    // Persistence counter, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !flag) begin
            cnt <= '0;
        end else if (tick && (cnt != CW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Trip on the tick beyond the window.
    always_comb begin
        trip = flag && tick && !clr && (cnt == CW'(LIMIT));
    end

endmodule

// File: rtl/otgseq_guard.sv
// Module: start/keep interlock and average-current compare.
// permit is high while every condition for boost holds; ilim_hit is high
// when the average current meets or exceeds the selected limit.
// Assumes: all inputs are synchronous to clk.
module otgseq_guard
    import otgseq_pkg::*;
#(
    parameter int IW = 10
) (
    input  logic          otg_en_reg,
    input  logic          chg_en_n,
    input  logic          shdn,
    input  logic          vin_uvlo,
    input  logic          bat_uvlo,
    input  logic          tsd,
    input  logic [IW-1:0] ibat_avg,
    input  logic [1:0]    ilim_sel,
    output logic          permit,
    output logic          ilim_hit
);
    localparam int LW = (IW > 11) ? IW : 11;

    logic [LW-1:0] cur_ext;
    logic [LW-1:0] lim_ext;

    // Interlock: enable bit, charger pin high, no input, battery healthy.
    always_comb begin
        permit = otg_en_reg && chg_en_n && vin_uvlo && !bat_uvlo
                 && !shdn && !tsd;
    end

    // Average-current comparison at a common width.
    always_comb begin
        cur_ext  = LW'(ibat_avg);
        lim_ext  = LW'(ilim_ma(ilim_sel));
        ilim_hit = (cur_ext >= lim_ext);
    end

endmodule

// File: rtl/otgseq_gates.sv
// Module: state-to-gate-control decoder.
// Each gate control is active in a contiguous range of states; the ranges
// are held in parameter tables and expanded by a generate loop.
// Assumes: state comes straight from a register, so outputs are glitch-free.
module otgseq_gates
    import otgseq_pkg::*;
#(
    parameter int NG = 5
) (
    input  bst_state_e   state,
    output logic [NG-1:0] gate
);
    // Order: linear, switching, ramp, run, pmos.
    localparam logic [2:0] LO [5] = '{3'd2, 3'd3, 3'd4, 3'd5, 3'd2};
    localparam logic [2:0] HI [5] = '{3'd2, 3'd5, 3'd4, 3'd5, 3'd5};

    for (genvar g = 0; g < NG; g++) begin : g_gate
        // Range decode for one gate control.
        always_comb begin
            gate[g] = (state >= LO[g]) && (state <= HI[g]);
        end
    end

endmodule

// File: rtl/otgseq_fsm.sv
// Module: boost start-up / run / shutdown state machine.
// Walks the soft-start phases on tick counts, applies the protective exits
// with priority short > over-voltage > current limit > permit loss, and
// waits in shutdown until the enable bit is cleared.
// Assumes: tick is a single-cycle pulse; fault inputs are synchronous.
module otgseq_fsm
    import otgseq_pkg::*;
#(
    parameter int WAIT_TICKS  = 2,
    parameter int LIN_TICKS   = 3,
    parameter int SW_TICKS    = 3,
    parameter int RAMP_TICKS  = 4,
    parameter int PMOFF_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       permit,
    input  logic       otg_en_reg,
    input  logic       short_det,
    input  logic       ovp_trip,
    input  logic       ilim_hit,
    output bst_state_e state,
    output logic       boosting,
    output logic       short_sticky,
    output logic       alm_short,
    output logic       alm_ovp,
    output logic       alm_ilim
);
    localparam int M1   = (WAIT_TICKS > LIN_TICKS) ? WAIT_TICKS : LIN_TICKS;
    localparam int M2   = (SW_TICKS > RAMP_TICKS) ? SW_TICKS : RAMP_TICKS;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXT = (M3 > PMOFF_TICKS) ? M3 : PMOFF_TICKS;
    localparam int TW   = $clog2(MAXT + 1);

    bst_state_e    nxt;
    logic [TW-1:0] cnt;
    logic [TW-1:0] len;
    logic          startup;
    logic          timed;
    logic          phase_done;
    logic          f_short;
    logic          f_ovp;
    logic          f_ilim;
    logic          stop;

    // Phase length of the current timed state.
    always_comb begin
        case (state)
            BST_WAIT:  len = TW'(WAIT_TICKS);
            BST_LINSS: len = TW'(LIN_TICKS);
            BST_SWSS:  len = TW'(SW_TICKS);
            BST_FRAMP: len = TW'(RAMP_TICKS);
            BST_PMOFF: len = TW'(PMOFF_TICKS);
            default:   len = TW'(1);
        endcase
    end

    // State classes and qualified faults.
    always_comb begin
        startup    = (state >= BST_WAIT) && (state <= BST_FRAMP);
        boosting   = startup || (state == BST_RUN);
        timed      = startup || (state == BST_PMOFF);
        phase_done = timed && tick && (cnt == len - 1'b1);
        f_short    = startup && short_det;
        f_ovp      = boosting && ovp_trip;
        f_ilim     = boosting && ilim_hit;
        stop       = f_short || f_ovp || f_ilim || (boosting && !permit);
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            BST_IDLE:  if (permit) nxt = BST_WAIT;
            BST_WAIT:  if (stop) nxt = BST_PMOFF;
                       else if (phase_done) nxt = BST_LINSS;
            BST_LINSS: if (stop) nxt = BST_PMOFF;
                       else if (phase_done) nxt = BST_SWSS;
            BST_SWSS:  if (stop) nxt = BST_PMOFF;
                       else if (phase_done) nxt = BST_FRAMP;
            BST_FRAMP: if (stop) nxt = BST_PMOFF;
                       else if (phase_done) nxt = BST_RUN;
            BST_RUN:   if (stop) nxt = BST_PMOFF;
            BST_PMOFF: if (phase_done) nxt = BST_SHUT;
            BST_SHUT:  if (!otg_en_reg) nxt = BST_IDLE;
            default:   nxt = BST_IDLE;
        endcase
    end

    // State register and per-phase tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt <= '0;
            end else if (tick && timed) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Alarm pulses, one per stop, by priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_short <= 1'b0;
            alm_ovp   <= 1'b0;
            alm_ilim  <= 1'b0;
        end else begin
            alm_short <= f_short;
            alm_ovp   <= f_ovp && !f_short;
            alm_ilim  <= f_ilim && !f_short && !f_ovp;
        end
    end

    // Start-up short status, cleared when a new session begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_sticky <= 1'b0;
        end else if ((state == BST_IDLE) && (nxt == BST_WAIT)) begin
            short_sticky <= 1'b0;
        end else if (f_short) begin
            short_sticky <= 1'b1;
        end
    end

endmodule

// File: rtl/otg_boost_seq.sv
// Module: top of the OTG boost enable sequencer.
// Combines the interlock/limit guard, the over-voltage persistence filter,
// the sequencing state machine and the gate-control decoder.
// Assumes: all inputs synchronous to clk; tick_1ms is a one-cycle pulse.
module otg_boost_seq
    import otgseq_pkg::*;
#(
    parameter int IW          = 10,
    parameter int WAIT_TICKS  = 2,
    parameter int LIN_TICKS   = 3,
    parameter int SW_TICKS    = 3,
    parameter int RAMP_TICKS  = 4,
    parameter int PMOFF_TICKS = 2,
    parameter int OVP_TICKS   = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1ms,
    input  logic          otg_en_reg,
    input  logic          chg_en_n,
    input  logic          shdn,
    input  logic          vin_uvlo,
    input  logic          bat_uvlo,
    input  logic          tsd,
    input  logic          vout_ovp,
    input  logic          vout_short,
    input  logic [IW-1:0] ibat_avg,
    input  logic [1:0]    ilim_sel,
    output logic [2:0]    boost_state,
    output logic          lin_ss_en,
    output logic          sw_ss_en,
    output logic          framp_en,
    output logic          run_en,
    output logic          pmos_en,
    output logic          short_sticky,
    output logic          alm_short,
    output logic          alm_ovp,
    output logic          alm_ilim
);
    localparam int NG = 5;

    logic          permit;
    logic          ilim_hit;
    logic          ovp_trip;
    logic          boosting;
    bst_state_e    state;
    logic [NG-1:0] gate;

    otgseq_guard #(.IW(IW)) u_guard (
        .otg_en_reg (otg_en_reg),
        .chg_en_n   (chg_en_n),
        .shdn       (shdn),
        .vin_uvlo   (vin_uvlo),
        .bat_uvlo   (bat_uvlo),
        .tsd        (tsd),
        .ibat_avg   (ibat_avg),
        .ilim_sel   (ilim_sel),
        .permit     (permit),
        .ilim_hit   (ilim_hit)
    );

    otgseq_deglitch #(.LIMIT(OVP_TICKS)) u_ovp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!boosting),
        .flag  (vout_ovp),
        .tick  (tick_1ms),
        .trip  (ovp_trip)
    );

    otgseq_fsm #(
        .WAIT_TICKS  (WAIT_TICKS),
        .LIN_TICKS   (LIN_TICKS),
        .SW_TICKS    (SW_TICKS),
        .RAMP_TICKS  (RAMP_TICKS),
        .PMOFF_TICKS (PMOFF_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick_1ms),
        .permit       (permit),
        .otg_en_reg   (otg_en_reg),
        .short_det    (vout_short),
        .ovp_trip     (ovp_trip),
        .ilim_hit     (ilim_hit),
        .state        (state),
        .boosting     (boosting),
        .short_sticky (short_sticky),
        .alm_short    (alm_short),
        .alm_ovp      (alm_ovp),
        .alm_ilim     (alm_ilim)
    );

    otgseq_gates #(.NG(NG)) u_gates (
        .state (state),
        .gate  (gate)
    );

    // Output mapping.
    always_comb begin
        boost_state = state;
        lin_ss_en   = gate[0];
        sw_ss_en    = gate[1];
        framp_en    = gate[2];
        run_en      = gate[3];
        pmos_en     = gate[4];
    end

endmodule

// File: rtl/otg_boost_seq_chk.sv
// Module: protocol checker for the boost sequencer, bound to the top.
// Assumes: observes ports only.
module otg_boost_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       otg_en_reg,
    input logic       chg_en_n,
    input logic       shdn,
    input logic       vin_uvlo,
    input logic       bat_uvlo,
    input logic       tsd,
    input logic [2:0] boost_state,
    input logic       lin_ss_en,
    input logic       sw_ss_en,
    input logic       framp_en,
    input logic       run_en,
    input logic       pmos_en,
    input logic       short_sticky,
    input logic       alm_short,
    input logic       alm_ovp,
    input logic       alm_ilim
);
    logic permit_in;

    // Permit as seen at the ports.
    always_comb begin
        permit_in = otg_en_reg && chg_en_n && vin_uvlo && !bat_uvlo
                    && !shdn && !tsd;
    end

    // R1
    start_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_state == 3'd1 && $past(boost_state) == 3'd0)
        |-> $past(permit_in));

    // R2
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_state >= 3'd1 && boost_state <= 3'd4)
        |=> (boost_state == $past(boost_state)
             || boost_state == $past(boost_state) + 3'd1
             || boost_state == 3'd6));

    // R3
    run_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> (sw_ss_en && pmos_en && !lin_ss_en && !framp_en));

    // R4
    permit_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_state == 3'd5 && !permit_in) |=> (boost_state == 3'd6));

    // R7
    short_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_short |-> short_sticky);

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_state == 3'd0 && $past(boost_state) != 3'd0)
        |-> ($past(boost_state) == 3'd7 && !$past(otg_en_reg)));

    // R10
    alarm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alm_short, alm_ovp, alm_ilim}));

    // R10
    alarm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_short || alm_ovp || alm_ilim)
        |=> !(alm_short || alm_ovp || alm_ilim));

endmodule

bind otg_boost_seq otg_boost_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .otg_en_reg   (otg_en_reg),
    .chg_en_n     (chg_en_n),
    .shdn         (shdn),
    .vin_uvlo     (vin_uvlo),
    .bat_uvlo     (bat_uvlo),
    .tsd          (tsd),
    .boost_state  (boost_state),
    .lin_ss_en    (lin_ss_en),
    .sw_ss_en     (sw_ss_en),
    .framp_en     (framp_en),
    .run_en       (run_en),
    .pmos_en      (pmos_en),
    .short_sticky (short_sticky),
    .alm_short    (alm_short),
    .alm_ovp      (alm_ovp),
    .alm_ilim     (alm_ilim)
);

// File: tb/otg_boost_seq_test.sv
module otg_boost_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 44;

    typedef struct packed {
        logic       en;
        logic       cen;
        logic       sd;
        logic       vuv;
        logic       buv;
        logic       ts;
        logic       sh;
        logic       ov;
        logic [1:0] sel;
        logic [9:0] ibat;
        logic [7:0] tk;
        logic [2:0] st;
        logic       stk;
        logic [3:0] req;
    } vec_t;

    // en cen sd vuv buv ts sh ov sel ibat ticks state sticky req
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd0,1'b0,4'd1},  // R1 enable low
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd1,1'b0,4'd1},  // R1 start
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd1 ,3'd1,1'b0,4'd2},  // R2 wait
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd1 ,3'd2,1'b0,4'd2},  // R2 linear
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd3 ,3'd3,1'b0,4'd2},  // R2 switching
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd3 ,3'd4,1'b0,4'd2},  // R2 ramp
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd3 ,3'd4,1'b0,4'd2},  // R2 ramp length
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd1 ,3'd5,1'b0,4'd2},  // R2 run
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd449,8'd1 ,3'd5,1'b0,4'd6},  // R6 below 450
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd450,8'd0 ,3'd6,1'b0,4'd6},  // R6 at 450
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd450,8'd2 ,3'd7,1'b0,4'd8},  // R8 pmos-off length
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd1 ,3'd7,1'b0,4'd8},  // R8 no restart
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd0,1'b0,4'd8},  // R8 rearm
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd1,1'b0,4'd1},  // R1 restart
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'd1,10'd100,8'd0 ,3'd6,1'b1,4'd7},  // R7 short at start-up
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd2 ,3'd0,1'b1,4'd7},  // R7 sticky held
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd1,1'b0,4'd7},  // R7 sticky cleared
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd6,1'b0,4'd4},  // R4 pin low
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd2 ,3'd0,1'b0,4'd8},  // R8 back to idle
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd1 ,3'd0,1'b0,4'd1},  // R1 shutdown pin
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd1,10'd100,8'd1 ,3'd0,1'b0,4'd1},  // R1 battery low
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd1 ,3'd0,1'b0,4'd1},  // R1 input present
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'd1,10'd100,8'd1 ,3'd0,1'b0,4'd1},  // R1 thermal
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd1,1'b0,4'd1},  // R1 permit met
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd12,3'd5,1'b0,4'd2},  // R2 full start-up
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'd1,10'd100,8'd1 ,3'd5,1'b0,4'd7},  // R7 short in run
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,10'd949,8'd1 ,3'd5,1'b0,4'd6},  // R6 code 11
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd2,10'd549,8'd1 ,3'd5,1'b0,4'd6},  // R6 code 10
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,10'd349,8'd1 ,3'd5,1'b0,4'd6},  // R6 code 00
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,10'd350,8'd0 ,3'd6,1'b0,4'd6},  // R6 at 350
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd2 ,3'd0,1'b0,4'd8},  // R8 idle
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd13,3'd5,1'b0,4'd2},  // R2 into run
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'd1,10'd100,8'd30,3'd5,1'b0,4'd5},  // R5 window edge
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'd1,10'd100,8'd1 ,3'd6,1'b0,4'd5},  // R5 trip
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd2 ,3'd0,1'b0,4'd8},  // R8 idle
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd13,3'd5,1'b0,4'd2},  // R2 into run
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'd1,10'd100,8'd20,3'd5,1'b0,4'd5},  // R5 first stretch
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd5,1'b0,4'd5},  // R5 drop
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'd1,10'd100,8'd20,3'd5,1'b0,4'd5},  // R5 count restarted
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd6,1'b0,4'd4},  // R4 enable cleared
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd2 ,3'd0,1'b0,4'd8},  // R8 idle
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd13,3'd5,1'b0,4'd2},  // R2 into run
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd1,10'd100,8'd0 ,3'd6,1'b0,4'd4},  // R4 battery low
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,10'd100,8'd2 ,3'd0,1'b0,4'd8}   // R8 idle
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_1ms;
    logic       otg_en_reg, chg_en_n, shdn, vin_uvlo, bat_uvlo, tsd;
    logic       vout_ovp, vout_short;
    logic [9:0] ibat_avg;
    logic [1:0] ilim_sel;
    logic [2:0] boost_state;
    logic       lin_ss_en, sw_ss_en, framp_en, run_en, pmos_en;
    logic       short_sticky, alm_short, alm_ovp, alm_ilim;

    int checks = 0;
    int failures = 0;
    int n_short = 0;
    int n_ovp = 0;
    int n_ilim = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    otg_boost_seq uut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
        .otg_en_reg(otg_en_reg), .chg_en_n(chg_en_n), .shdn(shdn),
        .vin_uvlo(vin_uvlo), .bat_uvlo(bat_uvlo), .tsd(tsd),
        .vout_ovp(vout_ovp), .vout_short(vout_short),
        .ibat_avg(ibat_avg), .ilim_sel(ilim_sel),
        .boost_state(boost_state), .lin_ss_en(lin_ss_en),
        .sw_ss_en(sw_ss_en), .framp_en(framp_en), .run_en(run_en),
        .pmos_en(pmos_en), .short_sticky(short_sticky),
        .alm_short(alm_short), .alm_ovp(alm_ovp), .alm_ilim(alm_ilim)
    );

    // Alarm pulse counters, sampled mid-cycle (R10).
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (alm_short) n_short++;
            if (alm_ovp)   n_ovp++;
            if (alm_ilim)  n_ilim++;
        end
    end

    // Expected gate pattern {lin, sw, ramp, run, pmos} per R3.
    function automatic logic [4:0] exp_gates(input logic [2:0] st);
        exp_gates = {st == 3'd2, (st >= 3'd3 && st <= 3'd5), st == 3'd4,
                     st == 3'd5, (st >= 3'd2 && st <= 3'd5)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_ticks(input int n);
        if (n == 0) begin
            @(negedge clk);
            @(negedge clk);
        end else begin
            for (int i = 0; i < n; i++) begin
                tick_1ms = 1'b1;
                @(negedge clk);
                tick_1ms = 1'b0;
                @(negedge clk);
            end
        end
    endtask

    task automatic apply(input vec_t v);
        otg_en_reg = v.en;  chg_en_n = v.cen; shdn = v.sd;
        vin_uvlo = v.vuv;   bat_uvlo = v.buv; tsd = v.ts;
        vout_short = v.sh;  vout_ovp = v.ov;
        ilim_sel = v.sel;   ibat_avg = v.ibat;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        tick_1ms = 1'b0;
        apply(VT[0]);
        repeat (3) @(negedge clk);
        // R9 state during and right after reset
        check("R9", "state in reset", 32'(boost_state), 32'd0);
        check("R9", "gates in reset",
              32'({lin_ss_en, sw_ss_en, framp_en, run_en, pmos_en}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "state after reset", 32'(boost_state), 32'd0);
        check("R9", "sticky after reset", 32'(short_sticky), 32'd0);
        check("R9", "alarms after reset",
              32'({alm_short, alm_ovp, alm_ilim}), 32'd0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            string rq;
            rq = $sformatf("R%0d", VT[k].req);
            apply(VT[k]);
            run_ticks(int'(VT[k].tk));
            check(rq, $sformatf("state step %0d", k), 32'(boost_state), 32'(VT[k].st));
            check("R3", $sformatf("gates step %0d", k),
                  32'({lin_ss_en, sw_ss_en, framp_en, run_en, pmos_en}),
                  32'(exp_gates(VT[k].st)));
            check("R7", $sformatf("sticky step %0d", k), 32'(short_sticky), 32'(VT[k].stk));
        end

        // R10 one alarm per faulted stop, none for plain aborts
        check("R10", "short alarms", 32'(n_short), 32'd1);
        check("R5", "ovp alarms", 32'(n_ovp), 32'd1);
        check("R6", "ilim alarms", 32'(n_ilim), 32'd2);

        // R10 short together with current limit: only the short alarm
        apply(VT[13]);
        run_ticks(0);
        vout_short = 1'b1;
        ibat_avg = 10'd900;
        run_ticks(0);
        check("R10", "short wins short", 32'(n_short), 32'd2);
        check("R10", "short wins ilim", 32'(n_ilim), 32'd2);

        // R9 reset mid-session clears sticky and state
        otg_en_reg = 1'b0;
        vout_short = 1'b0;
        ibat_avg = 10'd100;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "state after mid reset", 32'(boost_state), 32'd0);
        check("R9", "sticky after mid reset", 32'(short_sticky), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule